// File: doc/BRIEF.md
# Partial-Sum Vector Reduction Unit

This block reduces a stream of integer elements to one sum. A start pulse gives it the element count N. The elements then arrive as a series of beats, each carrying one chunk of VL lanes, through a valid/ready handshake. Lane i of a beat adds into its own partial-sum register, so after the last chunk the block holds VL partial sums. A halving tree then folds the upper half of the partial-sum vector into the lower half, once per cycle, until a single value is left. That value is presented with a one-cycle done strobe.

When N is not a multiple of VL, the final beat carries fewer valid elements than there are lanes. The lanes past the remainder are masked, so whatever they carry adds nothing. Addition is plain unsigned integer arithmetic that wraps modulo 2^SW. VL (the `LANES` parameter) must be a power of two, at least 2.

Top module: `lane_sum_reducer`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `done_o` and `in_ready_o` are 0 and `sum_o` is 0.
- R2: A `start_i` pulse seen while the block is idle, with `count_i` nonzero, raises `in_ready_o` in the next cycle. `in_ready_o` then stays high until all ceil(N/VL) beats are accepted, and a `start_i` pulse while busy has no effect on the result.
- R3: All partial sums are cleared when a start is accepted, so the result of a run depends only on that run's elements.
- R4: Each accepted beat (valid and ready both high at a clock edge) adds lane i, taken from bits [i*DW +: DW] and zero-extended, into partial sum i. The result is the sum of all N elements.
- R5: In the final beat, only lanes i < (N mod VL) contribute, unless N is a multiple of VL. Lanes at or above the remainder contribute zero whatever they carry.
- R6: `in_ready_o` is low while idle, during the tree phase and while `done_o` is high, and beats offered while it is low are ignored.
- R7: The tree phase takes log2(VL) cycles. `done_o` is high in the log2(VL)-th cycle after the clock edge that accepts the last beat.
- R8: `done_o` is high for exactly one cycle. `sum_o` changes only in the cycle `done_o` rises and holds its value until the next completion.
- R9: A start with `count_i` equal to 0 accepts no beats and completes with `sum_o` equal to 0 after log2(VL) cycles.
- R10: Sums wrap modulo 2^SW when the true total exceeds the SW-bit range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Begin a new reduction (taken only when idle) |
| count_i | input | NW | Total number of elements N for this run |
| in_valid_i | input | 1 | A chunk is present on `in_data_i` |
| in_data_i | input | LANES*DW | Chunk of VL elements, lane i in bits [i*DW +: DW] |
| in_ready_o | output | 1 | Block accepts a chunk this cycle |
| sum_o | output | SW | Final reduced sum |
| done_o | output | 1 | One-cycle strobe marking a new result on `sum_o` |

## Verification
The bench builds the block with LANES=4, DW=8, SW=10 and NW=8. With four lanes, both a remainder of three and a remainder of two in the final chunk can be reached with short vectors, and the two-step tree gives a latency that is easy to count exactly. The narrow 10-bit sum lets eight 8-bit elements overflow it, which exercises the wraparound. The 8-bit count still allows runs of several beats, with idle gaps and stray start pulses in between.

// File: rtl/lsr_pkg.sv
// Package lsr_pkg
// Shared definitions for the partial-sum reduction unit: the controller
// state encoding used by the controller, the top level and the checker.
package lsr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ACCUM = 2'd1,
        ST_TREE  = 2'd2
    } red_state_e;

endpackage

// File: rtl/lsr_lane_mask.sv
// Module lsr_lane_mask
// Works out which lanes of the current beat carry real elements. A lane
// is enabled when its index is below the number of elements still owed.
// Assumes rem_i holds the count of elements not yet accepted.
module lsr_lane_mask #(
    parameter int LANES = 8,
    parameter int NW    = 16
) (
    input  logic [NW-1:0]    rem_i,
    output logic [LANES-1:0] en_o
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // enable lane g while more than g elements remain
        assign en_o[g] = (rem_i > NW'(g));
    end

endmodule

// File: rtl/lsr_ctrl.sv
// Module lsr_ctrl
// Sequencer for one reduction: idle, chunk accumulation, then the halving
// tree. Tracks the remaining element count and the current fold width.
// Assumes LANES is a power of two of at least 2, and that beat_i is high
// only while the block reports ready.
module lsr_ctrl
    import lsr_pkg::*;
#(
    parameter int LANES = 8,
    parameter int NW    = 16,
    localparam int LOG  = $clog2(LANES),
    localparam int HW   = (LOG < 1) ? 1 : LOG
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [NW-1:0] count_i,
    input  logic          beat_i,
    output red_state_e    st_o,
    output logic [NW-1:0] rem_o,
    output logic          clear_o,
    output logic          acc_o,
    output logic          tree_o,
    output logic [HW-1:0] half_o,
    output logic          last_o
);

    localparam logic [HW-1:0] HALF_INIT = HW'(LANES / 2);
    localparam logic [NW-1:0] CHUNK     = NW'(LANES);

    red_state_e    st_q;
    logic [NW-1:0] rem_q;
    logic [HW-1:0] half_q;

    // state, remaining count and fold width register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            rem_q  <= '0;
            half_q <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (start_i) begin
                        rem_q <= count_i;
                        if (count_i == '0) begin
                            st_q   <= ST_TREE;
                            half_q <= HALF_INIT;
                        end else begin
                            st_q <= ST_ACCUM;
                        end
                    end
                end
                ST_ACCUM: begin
                    if (beat_i) begin
                        if (rem_q <= CHUNK) begin
                            rem_q  <= '0;
                            st_q   <= ST_TREE;
                            half_q <= HALF_INIT;
                        end else begin
                            rem_q <= rem_q - CHUNK;
                        end
                    end
                end
                ST_TREE: begin
                    half_q <= half_q >> 1;
                    if (half_q == HW'(1)) begin
                        st_q <= ST_IDLE;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // decode the datapath controls from the current state
    always_comb begin
        st_o    = st_q;
        rem_o   = rem_q;
        half_o  = half_q;
        clear_o = (st_q == ST_IDLE) && start_i;
        acc_o   = (st_q == ST_ACCUM) && beat_i;
        tree_o  = (st_q == ST_TREE);
        last_o  = (st_q == ST_TREE) && (half_q == HW'(1));
    end

endmodule

// File: rtl/lsr_bank.sv
// Module lsr_bank
// Holds the LANES partial sums. It clears them, adds one masked chunk
// lane by lane, or folds the upper half of the active width into the
// lower half. Exposes the next value of partial sum 0 for result capture.
// Assumes at most one of clear_i, acc_i, tree_i is high in a cycle.
module lsr_bank #(
    parameter int LANES = 8,
    parameter int DW    = 16,
    parameter int SW    = 32,
    localparam int LOG  = $clog2(LANES),
    localparam int HW   = (LOG < 1) ? 1 : LOG
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear_i,
    input  logic                acc_i,
    input  logic [LANES-1:0]    lane_en_i,
    input  logic [LANES*DW-1:0] data_i,
    input  logic                tree_i,
    input  logic [HW-1:0]       half_i,
    output logic [SW-1:0]       head_nxt_o
);

    logic [SW-1:0] part_q   [LANES];
    logic [SW-1:0] part_nxt [LANES];

    // next value of every partial sum for the current operation
    always_comb begin
        for (int j = 0; j < LANES; j++) begin
            part_nxt[j] = part_q[j];
            if (clear_i) begin
                part_nxt[j] = '0;
            end else if (acc_i) begin
                if (lane_en_i[j]) begin
                    part_nxt[j] = part_q[j] + SW'(data_i[j*DW +: DW]);
                end
            end else if (tree_i) begin
                if (j < int'(half_i) && (j + int'(half_i)) < LANES) begin
                    part_nxt[j] = part_q[j] + part_q[j + int'(half_i)];
                end
            end
        end
    end

    // partial sum storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int j = 0; j < LANES; j++) begin
                part_q[j] <= '0;
            end
        end else begin
            for (int j = 0; j < LANES; j++) begin
                part_q[j] <= part_nxt[j];
            end
        end
    end

    // the folded head is what the final tree step produces
    assign head_nxt_o = part_nxt[0];

endmodule

// File: rtl/lane_sum_reducer.sv
// Module lane_sum_reducer
// Top level of the reduction unit. It accumulates N elements, arriving as
// LANES-wide chunks, into per-lane partial sums, then folds those in a
// log2(LANES)-step halving tree. The result is shown with a one-cycle
// done strobe. Assumes LANES is a power of two (>= 2); sums wrap at SW bits.
module lane_sum_reducer
    import lsr_pkg::*;
#(
    parameter int LANES = 8,
    parameter int DW    = 16,
    parameter int SW    = 32,
    parameter int NW    = 16,
    localparam int LOG  = $clog2(LANES),
    localparam int HW   = (LOG < 1) ? 1 : LOG
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [NW-1:0]       count_i,
    input  logic                in_valid_i,
    input  logic [LANES*DW-1:0] in_data_i,
    output logic                in_ready_o,
    output logic [SW-1:0]       sum_o,
    output logic                done_o
);

    red_state_e       st_w;
    logic [NW-1:0]    rem_w;
    logic             clear_w;
    logic             acc_w;
    logic             tree_w;
    logic [HW-1:0]    half_w;
    logic             last_w;
    logic [LANES-1:0] lane_en_w;
    logic [SW-1:0]    head_nxt_w;
    logic             beat_w;
    logic [SW-1:0]    sum_q;
    logic             done_q;

    // a beat is taken only in the accumulation phase
    assign in_ready_o = (st_w == ST_ACCUM);
    assign beat_w     = in_valid_i && in_ready_o;

    lsr_ctrl #(
        .LANES (LANES),
        .NW    (NW)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .count_i (count_i),
        .beat_i  (beat_w),
        .st_o    (st_w),
        .rem_o   (rem_w),
        .clear_o (clear_w),
        .acc_o   (acc_w),
        .tree_o  (tree_w),
        .half_o  (half_w),
        .last_o  (last_w)
    );

    lsr_lane_mask #(
        .LANES (LANES),
        .NW    (NW)
    ) u_mask (
        .rem_i (rem_w),
        .en_o  (lane_en_w)
    );

    lsr_bank #(
        .LANES (LANES),
        .DW    (DW),
        .SW    (SW)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (clear_w),
        .acc_i      (acc_w),
        .lane_en_i  (lane_en_w),
        .data_i     (in_data_i),
        .tree_i     (tree_w),
        .half_i     (half_w),
        .head_nxt_o (head_nxt_w)
    );

    // capture the result and raise done on the final fold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= last_w;
            if (last_w) begin
                sum_q <= head_nxt_w;
            end
        end
    end

    assign sum_o  = sum_q;
    assign done_o = done_q;

endmodule

// File: rtl/lsr_checker.sv
// Module lsr_checker
// Protocol and timing properties of lane_sum_reducer, bound to every
// instance. Counts tree-phase cycles itself so the fold length is checked
// without parameter-deep delays.
module lsr_checker
    import lsr_pkg::*;
#(
    parameter int LANES = 8,
    parameter int SW    = 32,
    parameter int NW    = 16,
    localparam int LOG  = $clog2(LANES)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic [NW-1:0] count_i,
    input logic          in_valid_i,
    input logic          in_ready_o,
    input logic [SW-1:0] sum_o,
    input logic          done_o,
    input red_state_e    st,
    input logic [NW-1:0] rem
);

    logic [LOG:0] tcnt_q;

    // count consecutive cycles spent folding
    always_ff @(posedge clk) begin
        if (!rst_n || st != ST_TREE) begin
            tcnt_q <= '0;
        end else begin
            tcnt_q <= tcnt_q + 1'b1;
        end
    end

    AST_START_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && start_i && count_i != '0) |=> in_ready_o); // R2

    AST_BEAT_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && in_ready_o && rem > NW'(LANES)) |=> (rem == $past(rem) - NW'(LANES))); // R4

    AST_DONE_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !in_ready_o); // R6

    AST_TREE_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_TREE && int'(tcnt_q) == LOG - 1) |=> done_o); // R7

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R8

    AST_SUM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(sum_o)); // R8

endmodule

bind lane_sum_reducer lsr_checker #(
    .LANES (LANES),
    .SW    (SW),
    .NW    (NW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .count_i    (count_i),
    .in_valid_i (in_valid_i),
    .in_ready_o (in_ready_o),
    .sum_o      (sum_o),
    .done_o     (done_o),
    .st         (st_w),
    .rem        (rem_w)
);

// File: tb/sim_lane_sum_reducer.sv
`timescale 1ns/1ps
// Directed bench for lane_sum_reducer: one task per scenario.
module sim_lane_sum_reducer;

    localparam int L   = 4;
    localparam int DW  = 8;
    localparam int SW  = 10;
    localparam int NW  = 8;
    localparam int LOG = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [NW-1:0] count_i = '0;
    logic          in_valid_i = 1'b0;
    logic [L*DW-1:0] in_data_i = '0;
    logic          in_ready_o;
    logic [SW-1:0] sum_o;
    logic          done_o;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] elem [0:63];

    always #2.5 clk = ~clk;

    lane_sum_reducer #(.LANES(L), .DW(DW), .SW(SW), .NW(NW)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .count_i    (count_i),
        .in_valid_i (in_valid_i),
        .in_data_i  (in_data_i),
        .in_ready_o (in_ready_o),
        .sum_o      (sum_o),
        .done_o     (done_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // one full reduction of elem[0..n-1]; optional idle gaps and stray pokes
    task automatic run_case(input string req, input int n, input bit gaps, input bit poke);
        int beats;
        int lat;
        int exp;
        int held;
        beats = (n + L - 1) / L;
        exp = 0;
        for (int i = 0; i < n; i++) exp = (exp + int'(elem[i])) % (1 << SW);
        start_i = 1'b1;
        count_i = NW'(n);
        @(negedge clk);
        start_i = 1'b0;
        count_i = '0;
        if (n > 0) chk("R2 ready after start", int'(in_ready_o), 1);
        for (int b = 0; b < beats; b++) begin
            if (gaps) begin
                in_valid_i = 1'b0;
                if (poke) begin
                    start_i = 1'b1;
                    count_i = NW'(1);
                end
                @(negedge clk);
                start_i = 1'b0;
                count_i = '0;
                chk("R2 ready held through gap", int'(in_ready_o), 1);
            end
            in_valid_i = 1'b1;
            for (int i = 0; i < L; i++) begin
                in_data_i[i*DW +: DW] = (b*L + i < n) ? elem[b*L + i] : 8'hFF;
            end
            @(negedge clk);
            in_valid_i = 1'b0;
        end
        lat = 0;
        while (!done_o && lat < 50) begin
            if (poke) begin
                in_valid_i = 1'b1;
                in_data_i = '1;
                chk("R6 not ready in tree", int'(in_ready_o), 0);
            end
            @(negedge clk);
            lat++;
        end
        in_valid_i = 1'b0;
        in_data_i = '0;
        chk((n == 0) ? "R9 latency" : "R7 latency", lat, LOG);
        chk("R6 not ready with done", int'(in_ready_o), 0);
        chk(req, int'(sum_o), exp);
        held = int'(sum_o);
        @(negedge clk);
        chk("R8 done one cycle", int'(done_o), 0);
        chk("R8 sum held", int'(sum_o), held);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 done in reset", int'(done_o), 0);
        chk("R1 ready in reset", int'(in_ready_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 done after reset", int'(done_o), 0);
        chk("R1 ready after reset", int'(in_ready_o), 0);
        chk("R1 sum after reset", int'(sum_o), 0);
    endtask

    task automatic t_full_chunks();
        for (int i = 0; i < 8; i++) elem[i] = 8'(i + 1);
        run_case("R4 two full chunks", 8, 1'b0, 1'b0);
    endtask

    task automatic t_partial();
        for (int i = 0; i < 6; i++) elem[i] = 8'(10 * i + 3);
        run_case("R5 remainder two", 6, 1'b0, 1'b0);
        for (int i = 0; i < 3; i++) elem[i] = 8'(7 + i);
        run_case("R5 single short beat", 3, 1'b0, 1'b0);
    endtask

    task automatic t_zero();
        run_case("R9 empty vector", 0, 1'b0, 1'b0);
    endtask

    task automatic t_idle_beats();
        // beats offered while idle must not reach the sums
        in_valid_i = 1'b1;
        in_data_i = '1;
        repeat (3) begin
            @(negedge clk);
            chk("R6 not ready while idle", int'(in_ready_o), 0);
        end
        in_valid_i = 1'b0;
        for (int i = 0; i < 11; i++) elem[i] = 8'(3 * i + 1);
        run_case("R6 gaps and stray pokes", 11, 1'b1, 1'b1);
    endtask

    task automatic t_wrap();
        for (int i = 0; i < 8; i++) elem[i] = 8'd200;
        run_case("R10 wraparound", 8, 1'b0, 1'b0);
    endtask

    task automatic t_clear();
        for (int i = 0; i < 4; i++) elem[i] = 8'd99;
        run_case("R3 first run", 4, 1'b0, 1'b0);
        for (int i = 0; i < 4; i++) elem[i] = 8'(i + 2);
        run_case("R3 second run independent", 4, 1'b0, 1'b0);
    endtask

    initial begin
        #(5.0 * 150000);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        t_reset();
        t_full_chunks();
        t_partial();
        t_zero();
        t_idle_beats();
        t_wrap();
        t_clear();
        finish_run();
    end

endmodule